// File: doc/BRIEF.md
# Port Control Set/Clear Register

This block holds the control bits of one storage port, together with their status view, behind a small memory-mapped register bus. Software does not write the control word directly. A write to the set address turns on every control bit that has a one in the write data. A write to the clear address, four bytes above it, turns off every control bit that has a one in the write data. A zero in either write leaves the bit as it was, so independent agents can change single bits without a read-modify-write.

Reading the set address returns live status, not the last value written. Each control bit reads back as its current state, and the top bit reports whether the port engine can take commands. Port reset comes up asserted and holds until software clears it. Device reset and port initialize are one-shot operations: software sets them, and they drop by themselves when the port engine signals completion with a single-cycle done pulse. The remaining bits are plain sticky controls. These are the interrupt write-one-to-clear mode, resume, 32-bit activation and port-multiplier enable. They drive the port engine and the interrupt logic directly.

Top module: `pctl_port_ctrl`

## Requirements
- R1: After synchronous reset, port reset (bit 0) and interrupt write-one-to-clear mode (bit 3) are one, all other control bits are zero, and a read of the set address returns 0x00000009.
- R2: A write at the set address (default 0x1000) sets each control bit whose write-data bit is one, leaves the others unchanged, and takes effect on the next clock edge.
- R3: A write at the clear address (set address + 4) clears each control bit whose write-data bit is one and leaves the others unchanged.
- R4: A read of the set address returns status combinationally, with control bits at their positions: 0 port reset, 1 device reset, 2 port initialize, 3 interrupt write-one-to-clear mode, 6 resume, 10 32-bit activation, 13 port-multiplier enable. Reads at any other address return zero.
- R5: Bit 31 of the status word is read-only. It equals the engine ready input while port reset is clear, and it reads zero while port reset is set. Writes to bit 31 have no effect.
- R6: Port reset stays set until it is cleared through the clear address. Done pulses do not affect it.
- R7: Device reset clears on the clock edge where its done input is high. Port initialize clears on the edge where its own done input is high. Each holds until then.
- R8: When a set write of device reset or port initialize falls in the same cycle as that bit's done pulse, the bit ends up set.
- R9: Bits outside the seven defined positions and bit 31 always read zero and ignore writes. Writes to addresses other than the set and clear addresses change nothing.
- R10: Each control output equals the state of its control bit as read back at its position.
- R11: Bus activity with write enable low changes no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register byte address |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data (ones select bits) |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| eng_ready_i | input | 1 | Port engine can accept commands |
| dev_rst_done_i | input | 1 | One-cycle pulse, device reset finished |
| port_init_done_i | input | 1 | One-cycle pulse, port initialize finished |
| port_rst_o | output | 1 | Port reset control |
| dev_rst_o | output | 1 | Device reset request |
| port_init_o | output | 1 | Port initialize request |
| irq_w1c_mode_o | output | 1 | Interrupt write-one-to-clear mode for the interrupt block |
| resume_o | output | 1 | Port resume control |
| act32_o | output | 1 | 32-bit command activation mode |
| pmul_en_o | output | 1 | Port-multiplier enable |

## Verification
The bench targets collisions on the self-clearing bits. A set write landing on the same edge as a done pulse must leave the bit set, and a design that let done win would silently drop a software request. It also checks that done pulses leave port reset untouched, and that the ready flag stays masked while port reset is set. A design that got either wrong would release the port or report it ready before software has cleared the reset. All-ones writes at both addresses, writes at foreign addresses, and writes with the strobe low catch designs that store undefined bits, let bit 31 be written, or decode only part of the address.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_CTRL  = 7;
    localparam int READY_POS = 31;

    // control index order inside the block
    localparam int IDX_PRST  = 0;
    localparam int IDX_DRST  = 1;
    localparam int IDX_INIT  = 2;
    localparam int IDX_W1C   = 3;
    localparam int IDX_RSUM  = 4;
    localparam int IDX_ACT32 = 5;
    localparam int IDX_PMUL  = 6;

    typedef struct packed {
        logic set_wr;
        logic clr_wr;
        logic rd_stat;
    } bus_dec_t;

    // bit position of each control in the software-visible word
    function automatic int ctrl_pos(input int idx);
        case (idx)
            IDX_PRST:  return 0;
            IDX_DRST:  return 1;
            IDX_INIT:  return 2;
            IDX_W1C:   return 3;
            IDX_RSUM:  return 6;
            IDX_ACT32: return 10;
            default:   return 13;
        endcase
    endfunction

    function automatic bit ctrl_rst_val(input int idx);
        return (idx == IDX_PRST) || (idx == IDX_W1C);
    endfunction

    function automatic bit ctrl_self_clr(input int idx);
        return (idx == IDX_DRST) || (idx == IDX_INIT);
    endfunction

    function automatic logic [DATA_W-1:0] defined_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_CTRL; i++) m[ctrl_pos(i)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pctl_bus_decode.sv
module pctl_bus_decode
    import pctl_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SET_OFFS = 16'h1000,
    parameter logic [ADDR_W-1:0] CLR_OFFS = 16'h1004
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output bus_dec_t          dec
);
    logic hit_set;
    logic hit_clr;

    always_comb begin
        hit_set     = (addr == SET_OFFS);
        hit_clr     = (addr == CLR_OFFS);
        dec.set_wr  = we & hit_set;
        dec.clr_wr  = we & hit_clr;
        dec.rd_stat = hit_set;
    end
endmodule

// File: rtl/pctl_ctrl_cell.sv
module pctl_ctrl_cell #(
    parameter bit RST_VAL  = 1'b0,
    parameter bit SELF_CLR = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic done_i,
    output logic q
);
    // set outranks clear and done; done only matters for one-shot bits
    always_ff @(posedge clk) begin
        if (rst)                     q <= RST_VAL;
        else if (set_i)              q <= 1'b1;
        else if (clr_i)              q <= 1'b0;
        else if (SELF_CLR && done_i) q <= 1'b0;
    end
endmodule

// File: rtl/pctl_status_mux.sv
module pctl_status_mux
    import pctl_pkg::*;
(
    input  logic [NUM_CTRL-1:0] ctrl_q,
    input  logic                ready_i,
    input  logic                rd_stat,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] word;

    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_CTRL; i++) word[ctrl_pos(i)] = ctrl_q[i];
        word[READY_POS] = ready_i & ~ctrl_q[IDX_PRST];
        rdata = rd_stat ? word : '0;
    end
endmodule

// File: rtl/pctl_port_ctrl.sv
module pctl_port_ctrl
    import pctl_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SET_OFFS = 16'h1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_ready_i,
    input  logic              dev_rst_done_i,
    input  logic              port_init_done_i,
    output logic              port_rst_o,
    output logic              dev_rst_o,
    output logic              port_init_o,
    output logic              irq_w1c_mode_o,
    output logic              resume_o,
    output logic              act32_o,
    output logic              pmul_en_o
);
    localparam logic [ADDR_W-1:0] CLR_OFFS = SET_OFFS + ADDR_W'(4);
    localparam logic [DATA_W-1:0] DEF_MASK = defined_mask();

    bus_dec_t            dec;
    logic [NUM_CTRL-1:0] ctrl_q;
    logic [NUM_CTRL-1:0] done_vec;
    logic                wdata_unused;

    assign wdata_unused = ^(bus_wdata & ~DEF_MASK);

    pctl_bus_decode #(
        .ADDR_W   (ADDR_W),
        .SET_OFFS (SET_OFFS),
        .CLR_OFFS (CLR_OFFS)
    ) u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .dec  (dec)
    );

    always_comb begin
        done_vec           = '0;
        done_vec[IDX_DRST] = dev_rst_done_i;
        done_vec[IDX_INIT] = port_init_done_i;
    end

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_cell
        pctl_ctrl_cell #(
            .RST_VAL  (ctrl_rst_val(g)),
            .SELF_CLR (ctrl_self_clr(g))
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (dec.set_wr & bus_wdata[ctrl_pos(g)]),
            .clr_i  (dec.clr_wr & bus_wdata[ctrl_pos(g)]),
            .done_i (done_vec[g]),
            .q      (ctrl_q[g])
        );
    end

    pctl_status_mux u_stat (
        .ctrl_q  (ctrl_q),
        .ready_i (eng_ready_i),
        .rd_stat (dec.rd_stat),
        .rdata   (bus_rdata)
    );

    assign port_rst_o     = ctrl_q[IDX_PRST];
    assign dev_rst_o      = ctrl_q[IDX_DRST];
    assign port_init_o    = ctrl_q[IDX_INIT];
    assign irq_w1c_mode_o = ctrl_q[IDX_W1C];
    assign resume_o       = ctrl_q[IDX_RSUM];
    assign act32_o        = ctrl_q[IDX_ACT32];
    assign pmul_en_o      = ctrl_q[IDX_PMUL];
endmodule

// File: rtl/pctl_port_ctrl_chk.sv
module pctl_port_ctrl_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SET_OFFS = 16'h1000
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              eng_ready_i,
    input logic              dev_rst_done_i,
    input logic              port_init_done_i,
    input logic              port_rst_o,
    input logic              dev_rst_o,
    input logic              port_init_o,
    input logic              irq_w1c_mode_o,
    input logic              resume_o,
    input logic              act32_o,
    input logic              pmul_en_o
);
    localparam logic [ADDR_W-1:0] CLR_OFFS = SET_OFFS + ADDR_W'(4);
    localparam logic [31:0] UNDEF_MASK = ~32'h8000_244F;

    logic set_wr, clr_wr, chk_unused;
    assign set_wr     = bus_we && (bus_addr == SET_OFFS);
    assign clr_wr     = bus_we && (bus_addr == CLR_OFFS);
    assign chk_unused = ^bus_wdata;

    a_r2_set_pmul: assert property (@(posedge clk) disable iff (rst)
        set_wr && bus_wdata[13] |=> pmul_en_o);
    a_r2_set_act32: assert property (@(posedge clk) disable iff (rst)
        set_wr && bus_wdata[10] |=> act32_o);
    a_r3_clr_resume: assert property (@(posedge clk) disable iff (rst)
        clr_wr && bus_wdata[6] |=> !resume_o);
    a_r3_clr_w1c: assert property (@(posedge clk) disable iff (rst)
        clr_wr && bus_wdata[3] && !set_wr |=> !irq_w1c_mode_o);
    a_r5_ready_flag: assert property (@(posedge clk) disable iff (rst)
        bus_addr == SET_OFFS |-> bus_rdata[31] == (eng_ready_i && !port_rst_o));
    a_r6_prst_hold: assert property (@(posedge clk) disable iff (rst)
        port_rst_o && !(clr_wr && bus_wdata[0]) |=> port_rst_o);
    a_r7_drst_done: assert property (@(posedge clk) disable iff (rst)
        dev_rst_o && dev_rst_done_i && !(set_wr && bus_wdata[1]) |=> !dev_rst_o);
    a_r7_init_done: assert property (@(posedge clk) disable iff (rst)
        port_init_o && port_init_done_i && !(set_wr && bus_wdata[2]) |=> !port_init_o);
    a_r8_set_beats_done: assert property (@(posedge clk) disable iff (rst)
        set_wr && bus_wdata[2] && port_init_done_i |=> port_init_o);
    a_r9_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & UNDEF_MASK) == 32'h0);
endmodule

bind pctl_port_ctrl pctl_port_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .SET_OFFS (SET_OFFS)
) u_chk (.*);

// File: tb/pctl_port_ctrl_test.sv
`timescale 1ns/1ps
module pctl_port_ctrl_test;
    localparam logic [15:0] SET_A = 16'h1000;
    localparam logic [15:0] CLR_A = 16'h1004;
    localparam logic [31:0] DEFM  = 32'h0000_244F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = SET_A;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_ready_i = 1'b0;
    logic        dev_rst_done_i = 1'b0;
    logic        port_init_done_i = 1'b0;
    logic        port_rst_o, dev_rst_o, port_init_o, irq_w1c_mode_o;
    logic        resume_o, act32_o, pmul_en_o;

    int  checks = 0;
    int  errors = 0;
    bit  run = 1'b0;
    logic [31:0] m_ctrl;

    always #2.5 clk = ~clk;

    pctl_port_ctrl uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] outs();
        return {25'd0, pmul_en_o, act32_o, resume_o, irq_w1c_mode_o,
                port_init_o, dev_rst_o, port_rst_o};
    endfunction

    // behavioural reference: word of control bits, updated per edge
    always @(posedge clk) begin
        logic [31:0] nx;
        if (rst) m_ctrl <= 32'h9;
        else begin
            nx = m_ctrl;
            if (dev_rst_done_i)   nx[1] = 1'b0;
            if (port_init_done_i) nx[2] = 1'b0;
            if (bus_we && bus_addr == SET_A) nx = nx | (bus_wdata & DEFM);
            if (bus_we && bus_addr == CLR_A) nx = nx & ~(bus_wdata & DEFM);
            m_ctrl <= nx;
        end
    end

    always @(negedge clk) begin
        if (run && !rst) begin
            logic [31:0] w;
            w = m_ctrl;
            w[31] = eng_ready_i & ~m_ctrl[0];
            chk("R4 read word", bus_rdata, (bus_addr == SET_A) ? w : 32'h0);
            chk("R10 outputs", outs(),
                {25'd0, m_ctrl[13], m_ctrl[10], m_ctrl[6], m_ctrl[3],
                 m_ctrl[2], m_ctrl[1], m_ctrl[0]});
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic we = 1'b1);
        @(posedge clk) #1;
        bus_addr = a; bus_we = we; bus_wdata = d;
        @(posedge clk) #1;
        bus_we = 1'b0; bus_addr = SET_A; bus_wdata = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        run = 1'b1;
        @(negedge clk);
        chk("R1 reset word", bus_rdata, 32'h0000_0009);
        chk("R1 reset outputs", outs(), 32'h09);

        // ready masked by port reset
        eng_ready_i = 1'b1;
        @(negedge clk);
        chk("R5 ready masked", bus_rdata[31], 1'b0);
        wr(CLR_A, 32'h1);
        chk("R5 ready shown", bus_rdata, 32'h8000_0008);
        wr(SET_A, 32'h8000_0000);
        chk("R5 bit31 write ignored", bus_rdata, 32'h8000_0008);

        // sticky sets
        wr(SET_A, 32'h0000_2440);
        chk("R2 set several", bus_rdata, 32'h8000_2448);
        wr(SET_A, 32'h0);
        chk("R2 zero write no change", bus_rdata, 32'h8000_2448);

        // clears
        wr(CLR_A, 32'h8);
        chk("R3 clear w1c", irq_w1c_mode_o, 1'b0);
        wr(CLR_A, 32'h40);
        chk("R3 clear resume only", bus_rdata, 32'h8000_2400);

        // undefined bits and foreign addresses
        wr(SET_A, 32'hFFFF_FFFF);
        chk("R9 all ones set", bus_rdata, 32'h0000_244F);
        wr(CLR_A, 32'hFFFF_FFFF);
        chk("R9 all ones clear", bus_rdata, 32'h8000_0000);
        wr(16'h1008, 32'hFFFF_FFFF);
        chk("R9 foreign address write", bus_rdata, 32'h8000_0000);
        bus_addr = CLR_A;
        @(negedge clk);
        chk("R4 clear address reads zero", bus_rdata, 32'h0);
        bus_addr = SET_A;
        wr(SET_A, 32'h0000_2445, 1'b0);
        chk("R11 strobe low", bus_rdata, 32'h8000_0000);

        // port reset ignores done pulses
        wr(SET_A, 32'h1);
        @(posedge clk) #1; dev_rst_done_i = 1'b1; port_init_done_i = 1'b1;
        @(posedge clk) #1; dev_rst_done_i = 1'b0; port_init_done_i = 1'b0;
        @(negedge clk);
        chk("R6 port reset held", port_rst_o, 1'b1);
        wr(CLR_A, 32'h1);

        // one-shot device reset
        wr(SET_A, 32'h2);
        repeat (3) @(negedge clk);
        chk("R7 dev reset holds", dev_rst_o, 1'b1);
        @(posedge clk) #1; dev_rst_done_i = 1'b1;
        @(negedge clk);
        chk("R7 dev reset before edge", dev_rst_o, 1'b1);
        @(posedge clk) #1; dev_rst_done_i = 1'b0;
        @(negedge clk);
        chk("R7 dev reset self clear", dev_rst_o, 1'b0);

        // one-shot port initialize
        wr(SET_A, 32'h4);
        @(posedge clk) #1; port_init_done_i = 1'b1;
        @(posedge clk) #1; port_init_done_i = 1'b0;
        @(negedge clk);
        chk("R7 init self clear", port_init_o, 1'b0);

        // collision: set and done same edge
        @(posedge clk) #1;
        bus_we = 1'b1; bus_wdata = 32'h6; dev_rst_done_i = 1'b1; port_init_done_i = 1'b1;
        @(posedge clk) #1;
        bus_we = 1'b0; bus_wdata = '0; dev_rst_done_i = 1'b0; port_init_done_i = 1'b0;
        @(negedge clk);
        chk("R8 set beats done", {30'd0, port_init_o, dev_rst_o}, 32'h3);

        // ready follows engine input
        eng_ready_i = 1'b0;
        @(negedge clk);
        chk("R5 ready low", bus_rdata[31], 1'b0);

        repeat (4) @(negedge clk);
        run = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule